// File: doc/BRIEF.md
# Framebuffer Rectangle Transfer Engine

The engine moves pixels between a 32-bit word stream and a frame memory that holds 1024 columns by 512 lines of 16-bit pixels. A start pulse brings a position word, a size word and a direction. The engine then walks the rectangle row by row. For a write, each accepted word supplies two pixels. For a read, each accepted request returns one word that holds two pixels, in the same order.

The geometry state is kept between words: the current line, the rows still to go and the offset inside a partly finished row. A transfer can therefore be fed in bursts of any length, with gaps of any length between them, and a burst can stop and resume in the middle of a row. Line addresses wrap at 512 and column addresses wrap at 1024. The frame memory sits outside the block behind a plain synchronous single-port RAM interface with a read latency of one cycle.

Top module: `fb_rect_mover`

## Requirements
- R1: After reset, xferActive, reqReady, memEn, memWe, rdValid, imgReady and overlapWarn are all 0.
- R2: A start cycle (startValid=1) loads start column = posWord[9:0], start line = posWord[24:16], width = sizeWord[15:0] and height = sizeWord[31:16]. All other position bits are ignored. xferActive is 1 from the next cycle while rows remain.
- R3: A word accepted in cycle n (reqValid and reqReady both 1) makes a memory access in cycle n for its low half (bits 15:0) and, if the transfer is still active, a second access in cycle n+1 for its high half (bits 31:16). memAddr = line*1024 + column, which is {line, column}.
- R4: The column of each access is (start column + row offset) mod 1024. When the row offset reaches the width, it returns to 0, the line advances modulo 512 and the remaining height drops by one.
- R5: The transfer ends when the remaining height reaches 0. After that there is no memory access, and the high half of a final half-used word is dropped. reqReady is 1 only while a transfer is active, no start is present and no second half is pending.
- R6: The row offset, line and remaining height are held unchanged for any number of idle cycles between words, so a transfer resumes mid-row.
- R7: A read word accepted in cycle n gives rdValid=1 for exactly one cycle in cycle n+3. rdData holds the first pixel in bits 15:0 and the second pixel in bits 31:16, or 0 in bits 31:16 when that pixel lay beyond the end of the rectangle.
- R8: imgReady is set by a read start (startRead=1) and cleared by a write start (startRead=0), from the cycle after the start.
- R9: overlapWarn is 1 for one cycle, in the cycle after a start, exactly when the previous transfer still had rows remaining.
- R10: A start with width 0 or height 0 leaves the engine idle: xferActive=0, reqReady=0 and no memory access.
- R11: In a write transfer, memWe equals memEn, and memWdata carries the low pixel and then the high pixel of the word. In a read transfer, memWe stays 0.
- R12: A start has priority over a request in the same cycle: that request is not accepted and no access is made in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Start a new rectangle transfer |
| startRead | input | 1 | Direction of the started transfer, 1 = read |
| posWord | input | 32 | Start position: column in bits 9:0, line in bits 24:16 |
| sizeWord | input | 32 | Size: width in bits 15:0, height in bits 31:16 |
| reqValid | input | 1 | Word request (write data or read request) |
| reqReady | output | 1 | Engine can take a word this cycle |
| reqData | input | 32 | Two pixels to write, first pixel in the low half |
| rdValid | output | 1 | Read word valid |
| rdData | output | 32 | Read word, first pixel in the low half |
| memEn | output | 1 | Frame memory access enable |
| memWe | output | 1 | Frame memory write enable |
| memAddr | output | 19 | Frame memory pixel address {line, column} |
| memWdata | output | 16 | Frame memory write pixel |
| memRdata | input | 16 | Frame memory read pixel, one cycle after the access |
| xferActive | output | 1 | Rows remain in the current transfer |
| imgReady | output | 1 | A read transfer has been started |
| overlapWarn | output | 1 | A start arrived while the previous transfer was unfinished |

## Verification
The assertions check on every cycle the properties that only relate handshakes and timing. They check that the second half of an accepted word follows in the next cycle, that a read word returns three cycles after acceptance, that an idle engine stays silent, that the line advances by at most one step per cycle, that a zero-sized start stays idle, and that the warning appears only after a start that lands on an unfinished transfer. Other behaviour can only be shown by the bench's scenarios, where a behavioural model predicts every port on every clock. This covers the exact addresses with column and line wrap, the row and offset bookkeeping across bursts with idle gaps, the dropped odd pixel at the end, and the pixels read back after a write.

// File: rtl/fbx_pkg.sv
package fbx_pkg;

  // Half of a word being processed: low pixel first, then high pixel.
  typedef enum logic {
    PH_LO = 1'b0,
    PH_HI = 1'b1
  } fbxPhase_e;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic loadGeom;   // capture a new rectangle
    logic stepPix;    // attempt one pixel access and advance the cursor
    logic pixSel;     // 0: low pixel from reqData, 1: latched high pixel
    logic latchHi;    // keep the high pixel of the accepted word
    logic capLo;      // read data for the low pixel is on memRdata
    logic capHi;      // read data for the high pixel is on memRdata
  } fbxStrobe_t;

endpackage

// File: rtl/fbx_control.sv
module fbx_control
  import fbx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startValid,
  input  logic       startRead,
  input  logic       reqValid,
  input  logic       active,
  input  logic       memEn,
  output logic       reqReady,
  output logic       memWe,
  output logic       readMode,
  output logic       imgReady,
  output fbxStrobe_t strb
);

  fbxPhase_e phase;
  logic      accept;
  logic      hiStep;
  logic      rdIssLo;
  logic      rdIssHi;

  assign reqReady = !startValid && (phase == PH_LO) && active;
  assign accept   = reqValid && reqReady;
  assign hiStep   = (phase == PH_HI) && !startValid;
  assign memWe    = memEn && !readMode;

  always_comb begin
    strb          = '0;
    strb.loadGeom = startValid;
    strb.stepPix  = accept || hiStep;
    strb.pixSel   = (phase == PH_HI);
    strb.latchHi  = accept;
    strb.capLo    = rdIssLo;
    strb.capHi    = rdIssHi;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= PH_LO;
      readMode <= 1'b0;
      imgReady <= 1'b0;
      rdIssLo  <= 1'b0;
      rdIssHi  <= 1'b0;
    end else begin
      rdIssLo <= accept && readMode;
      rdIssHi <= hiStep && readMode;
      if (startValid) begin
        phase    <= PH_LO;
        readMode <= startRead;
        imgReady <= startRead;
      end else if (accept) begin
        phase <= PH_HI;
      end else if (phase == PH_HI) begin
        phase <= PH_LO;
      end
    end
  end

  AST_IMG_FOLLOWS_DIR: assert property (@(posedge clk) disable iff (!rstN)
    $past(startValid) |-> (imgReady == $past(startRead)));  // R8

  AST_READ_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    readMode |-> !memWe);  // R11

endmodule

// File: rtl/fbx_datapath.sv
module fbx_datapath
  import fbx_pkg::*;
#(
  parameter int X_BITS    = 10,
  parameter int Y_BITS    = 9,
  parameter int PIX_W     = 16,
  parameter int DIM_W     = 16,
  parameter int POS_Y_LSB = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  fbxStrobe_t                 strb,
  input  logic [31:0]                posWord,
  input  logic [2*DIM_W-1:0]         sizeWord,
  input  logic [2*PIX_W-1:0]         reqData,
  input  logic [PIX_W-1:0]           memRdata,
  output logic                       active,
  output logic                       overlapWarn,
  output logic                       memEn,
  output logic [X_BITS+Y_BITS-1:0]   memAddr,
  output logic [PIX_W-1:0]           memWdata,
  output logic                       rdValid,
  output logic [2*PIX_W-1:0]         rdData
);

  localparam int SIZE_W = 2 * DIM_W;

  logic [X_BITS-1:0] xBase;
  logic [Y_BITS-1:0] yRow;
  logic [DIM_W-1:0]  rowLen;
  logic [DIM_W-1:0]  rowsLeft;
  logic [DIM_W-1:0]  colOff;
  logic [DIM_W-1:0]  colNext;
  logic              rowEnd;
  logic [X_BITS-1:0] colAddr;
  logic [DIM_W-1:0]  newW;
  logic [DIM_W-1:0]  newH;
  logic [PIX_W-1:0]  hiLatch;
  logic [PIX_W-1:0]  rdLo;
  logic              memEnD;
  logic              unusedPos;

  assign unusedPos = ^posWord;
  assign newW      = sizeWord[DIM_W-1:0];
  assign newH      = sizeWord[SIZE_W-1:DIM_W];

  assign active   = (rowsLeft != '0);
  assign memEn    = strb.stepPix && active;
  assign colNext  = colOff + 1'b1;
  assign rowEnd   = (colNext == rowLen);
  assign colAddr  = xBase + colOff[X_BITS-1:0];
  assign memAddr  = {yRow, colAddr};
  assign memWdata = strb.pixSel ? hiLatch : reqData[PIX_W-1:0];

  // Rectangle cursor
  always_ff @(posedge clk) begin
    if (!rstN) begin
      xBase       <= '0;
      yRow        <= '0;
      rowLen      <= '0;
      rowsLeft    <= '0;
      colOff      <= '0;
      overlapWarn <= 1'b0;
    end else if (strb.loadGeom) begin
      xBase       <= posWord[X_BITS-1:0];
      yRow        <= posWord[POS_Y_LSB +: Y_BITS];
      rowLen      <= newW;
      rowsLeft    <= (newW == '0) ? '0 : newH;
      colOff      <= '0;
      overlapWarn <= active;
    end else begin
      overlapWarn <= 1'b0;
      if (memEn) begin
        if (rowEnd) begin
          colOff   <= '0;
          yRow     <= yRow + 1'b1;
          rowsLeft <= rowsLeft - 1'b1;
        end else begin
          colOff <= colNext;
        end
      end
    end
  end

  // Word packing for both directions
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiLatch <= '0;
      rdLo    <= '0;
      memEnD  <= 1'b0;
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      memEnD  <= memEn;
      rdValid <= strb.capHi;
      if (strb.latchHi) hiLatch <= reqData[2*PIX_W-1:PIX_W];
      if (strb.capLo)   rdLo    <= memRdata;
      if (strb.capHi)   rdData  <= {(memEnD ? memRdata : '0), rdLo};
    end
  end

  AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    ($past(active) && !$past(strb.loadGeom)) |->
      ((yRow == $past(yRow)) || (yRow == Y_BITS'($past(yRow) + 1'b1))));  // R4

  AST_ROWS_NEVER_GROW: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.loadGeom) |-> (rowsLeft <= $past(rowsLeft)));  // R5

endmodule

// File: rtl/fb_rect_mover.sv
module fb_rect_mover
  import fbx_pkg::*;
#(
  parameter int X_BITS    = 10,
  parameter int Y_BITS    = 9,
  parameter int PIX_W     = 16,
  parameter int DIM_W     = 16,
  parameter int POS_Y_LSB = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      startValid,
  input  logic                      startRead,
  input  logic [31:0]               posWord,
  input  logic [2*DIM_W-1:0]        sizeWord,
  input  logic                      reqValid,
  output logic                      reqReady,
  input  logic [2*PIX_W-1:0]        reqData,
  output logic                      rdValid,
  output logic [2*PIX_W-1:0]        rdData,
  output logic                      memEn,
  output logic                      memWe,
  output logic [X_BITS+Y_BITS-1:0]  memAddr,
  output logic [PIX_W-1:0]          memWdata,
  input  logic [PIX_W-1:0]          memRdata,
  output logic                      xferActive,
  output logic                      imgReady,
  output logic                      overlapWarn
);

  fbxStrobe_t strb;
  logic       readMode;

  fbx_control ctl_i (
    .clk        (clk),
    .rstN       (rstN),
    .startValid (startValid),
    .startRead  (startRead),
    .reqValid   (reqValid),
    .active     (xferActive),
    .memEn      (memEn),
    .reqReady   (reqReady),
    .memWe      (memWe),
    .readMode   (readMode),
    .imgReady   (imgReady),
    .strb       (strb)
  );

  fbx_datapath #(
    .X_BITS    (X_BITS),
    .Y_BITS    (Y_BITS),
    .PIX_W     (PIX_W),
    .DIM_W     (DIM_W),
    .POS_Y_LSB (POS_Y_LSB)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .posWord     (posWord),
    .sizeWord    (sizeWord),
    .reqData     (reqData),
    .memRdata    (memRdata),
    .active      (xferActive),
    .overlapWarn (overlapWarn),
    .memEn       (memEn),
    .memAddr     (memAddr),
    .memWdata    (memWdata),
    .rdValid     (rdValid),
    .rdData      (rdData)
  );

  AST_HI_FOLLOWS_LO: assert property (@(posedge clk) disable iff (!rstN)
    ($past(reqValid && reqReady) && !startValid && xferActive) |-> memEn);  // R3

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && readMode) ##1 !startValid |=> ##1 rdValid);  // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !xferActive |-> (!memEn && !reqReady));  // R5

  AST_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(startValid) && (($past(sizeWord[DIM_W-1:0]) == '0) ||
                           ($past(sizeWord[2*DIM_W-1:DIM_W]) == '0))) |-> !xferActive);  // R10

  AST_WARN_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    overlapWarn |-> ($past(startValid) && $past(xferActive)));  // R9

  AST_START_WINS: assert property (@(posedge clk) disable iff (!rstN)
    startValid |-> !reqReady);  // R12

endmodule

// File: tb/fb_rect_mover_tb_top.sv
`timescale 1ns/1ps
module fb_rect_mover_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startValid = 1'b0, startRead = 1'b0, reqValid = 1'b0;
  logic [31:0] posWord = '0, sizeWord = '0, reqData = '0;
  logic        reqReady, rdValid, memEn, memWe, xferActive, imgReady, overlapWarn;
  logic [31:0] rdData;
  logic [18:0] memAddr;
  logic [15:0] memWdata;
  logic [15:0] memRdata = '0;

  always #2 clk = ~clk;  // 250 MHz

  fb_rect_mover dut_i (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startRead(startRead),
    .posWord(posWord), .sizeWord(sizeWord), .reqValid(reqValid), .reqReady(reqReady),
    .reqData(reqData), .rdValid(rdValid), .rdData(rdData), .memEn(memEn), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata), .xferActive(xferActive),
    .imgReady(imgReady), .overlapWarn(overlapWarn)
  );

  // Frame memory seen by the design
  logic [15:0] ram [int];
  always @(posedge clk) begin
    if (memEn) begin
      if (memWe) ram[int'(memAddr)] = memWdata;
      memRdata <= ram.exists(int'(memAddr)) ? ram[int'(memAddr)] : 16'h0;
    end
  end

  int checks = 0;
  int errors = 0;
  string curTag = "reset";

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s [%s] actual=%h expected=%h", req, what, curTag, act, exp);
    end
  endtask

  // Per-cycle stimulus
  typedef struct {
    bit          sv;
    bit          sr;
    logic [31:0] pos;
    logic [31:0] size;
    bit          rv;
    logic [31:0] data;
    string       tag;
  } stim_t;
  stim_t sq[$];

  function automatic logic [31:0] mkPos(int x, int y, logic [31:0] junk);
    return junk | (32'(y) << 16) | 32'(x);
  endfunction

  task automatic addStart(bit rd, logic [31:0] pos, int w, int h, bit withReq, string tag);
    stim_t s;
    s.sv = 1; s.sr = rd; s.pos = pos; s.size = (32'(h) << 16) | 32'(w);
    s.rv = withReq; s.data = 32'hDEAD_BEEF; s.tag = tag;
    sq.push_back(s);
  endtask

  task automatic addWords(int n, int base, string tag);
    for (int i = 0; i < n; i++) begin
      stim_t s;
      s.sv = 0; s.sr = 0; s.pos = '0; s.size = '0; s.rv = 1; s.tag = tag;
      s.data = {16'(base + 2*i + 1), 16'(base + 2*i)};
      sq.push_back(s);
    end
  endtask

  task automatic addIdle(int n, string tag);
    for (int i = 0; i < n; i++) begin
      stim_t s;
      s.sv = 0; s.sr = 0; s.pos = '0; s.size = '0; s.rv = 0; s.data = '0; s.tag = tag;
      sq.push_back(s);
    end
  endtask

  // Behavioural reference model
  typedef struct { int due; logic [31:0] w; } rdq_t;
  rdq_t        rdQ[$];
  logic [15:0] refMem [int];
  int          mX = 0, mY = 0, mW = 0, mH = 0, mOff = 0, cyc = 0;
  bit          mHiPhase = 0, mRd = 0, mImg = 0, mWarn = 0;
  logic [15:0] mHi = '0, mLo = '0;

  function automatic logic [15:0] refRd(int a);
    return refMem.exists(a) ? refMem[a] : 16'h0;
  endfunction

  task automatic stepCycle(stim_t s);
    bit expReady, acc, hiAcc, expEn, expRv;
    int addr;
    logic [15:0] wd, hiPix;
    startValid = s.sv; startRead = s.sr; posWord = s.pos; sizeWord = s.size;
    reqValid = s.rv; reqData = s.data; curTag = s.tag;
    #1;
    expReady = !s.sv && !mHiPhase && (mH != 0);
    acc      = s.rv && expReady;
    hiAcc    = mHiPhase && !s.sv && (mH != 0);
    expEn    = acc || hiAcc;
    addr     = mY * 1024 + ((mX + mOff) % 1024);
    wd       = acc ? s.data[15:0] : mHi;
    chk(reqReady === expReady, "R5", "reqReady", 32'(reqReady), 32'(expReady));
    chk(memEn === expEn, "R3", "memEn", 32'(memEn), 32'(expEn));
    chk(xferActive === (mH != 0), "R2", "xferActive", 32'(xferActive), 32'(mH != 0));
    chk(imgReady === mImg, "R8", "imgReady", 32'(imgReady), 32'(mImg));
    chk(overlapWarn === mWarn, "R9", "overlapWarn", 32'(overlapWarn), 32'(mWarn));
    if (expEn) begin
      chk(memAddr === 19'(addr), "R4", "memAddr", 32'(memAddr), 32'(addr));
      chk(memWe === !mRd, "R11", "memWe", 32'(memWe), 32'(!mRd));
      if (!mRd) chk(memWdata === wd, "R11", "memWdata", 32'(memWdata), 32'(wd));
    end else begin
      chk(memWe === 1'b0, "R11", "memWe idle", 32'(memWe), 32'h0);
    end
    expRv = (rdQ.size() > 0) && (rdQ[0].due == cyc);
    chk(rdValid === expRv, "R7", "rdValid", 32'(rdValid), 32'(expRv));
    if (expRv) begin
      chk(rdData === rdQ[0].w, "R7", "rdData", rdData, rdQ[0].w);
      void'(rdQ.pop_front());
    end
    // advance model over the coming clock edge
    if (expEn && !mRd) refMem[addr] = wd;
    if (acc && mRd) mLo = refRd(addr);
    if (mHiPhase && !s.sv && mRd) begin
      rdq_t e;
      hiPix = hiAcc ? refRd(addr) : 16'h0;
      e.due = cyc + 2; e.w = {hiPix, mLo};
      rdQ.push_back(e);
    end
    if (s.sv) begin
      mWarn = (mH != 0);
      mX = int'(s.pos[9:0]); mY = int'(s.pos[24:16]);
      mW = int'(s.size[15:0]); mH = (mW == 0) ? 0 : int'(s.size[31:16]);
      mOff = 0; mHiPhase = 0; mRd = s.sr; mImg = s.sr;
    end else begin
      mWarn = 0;
      if (expEn) begin
        if (mOff + 1 == mW) begin
          mOff = 0; mY = (mY + 1) % 512; mH = mH - 1;
        end else begin
          mOff = mOff + 1;
        end
      end
      if (acc) begin
        mHiPhase = 1; mHi = s.data[31:16];
      end else if (mHiPhase) begin
        mHiPhase = 0;
      end
    end
    cyc++;
  endtask

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired [%s]", curTag);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R2 and R4: junk in ignored position bits; column wraps at 1024, line at 512.
    // 15 pixels -> 8 words, last high half dropped (R5); idle gap mid-row (R6).
    addStart(0, mkPos(1020, 510, 32'hFE00_FC00), 5, 3, 0, "R2 R4 write wrap");
    addWords(6, 16'h100, "R6 write burst 1");
    addIdle(5, "R6 gap");
    addWords(14, 16'h200, "R5 write burst 2");
    addIdle(4, "R5 idle after end");
    // R7 and R8: read back the same rectangle in two bursts.
    addStart(1, mkPos(1020, 510, 32'h0), 5, 3, 0, "R8 read start");
    addWords(6, 0, "R7 read burst 1");
    addIdle(3, "R6 read gap");
    addWords(14, 0, "R7 read burst 2");
    addIdle(6, "R7 drain");
    // R9: a new start while the previous read still has rows.
    addStart(1, mkPos(100, 20, 32'h0), 4, 4, 0, "R9 first read");
    addWords(4, 0, "R9 partial read");
    addStart(0, mkPos(100, 20, 32'h0), 2, 2, 0, "R9 overlapping start");
    addWords(6, 16'h300, "R9 write after overlap");
    addIdle(4, "R9 drain");
    // R10: zero width and zero height.
    addStart(0, mkPos(5, 5, 32'h0), 0, 3, 0, "R10 zero width");
    addWords(4, 16'h400, "R10 words ignored w0");
    addStart(0, mkPos(5, 5, 32'h0), 4, 0, 0, "R10 zero height");
    addWords(4, 16'h500, "R10 words ignored h0");
    // R12: a start together with a request.
    addStart(0, mkPos(8, 8, 32'h0), 3, 1, 1, "R12 start with request");
    addWords(4, 16'h600, "R12 write");
    addIdle(3, "R12 drain");
    // R3 and R11: odd-width 3x3 write, then read back.
    addStart(0, mkPos(1023, 0, 32'h0), 3, 3, 0, "R11 odd write");
    addWords(10, 16'h700, "R11 odd write words");
    addStart(1, mkPos(1023, 0, 32'h0), 3, 3, 0, "R3 odd read");
    addWords(10, 0, "R3 odd read words");
    addIdle(6, "R3 drain");

    repeat (4) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk({xferActive, reqReady, memEn, memWe, rdValid, imgReady, overlapWarn} === 7'b0,
        "R1", "reset outputs",
        32'({xferActive, reqReady, memEn, memWe, rdValid, imgReady, overlapWarn}), 32'h0);
    while (sq.size() > 0) begin
      stim_t s;
      s = sq.pop_front();
      @(negedge clk);
      stepCycle(s);
    end
    chk(xferActive === 1'b0, "R5", "final idle", 32'(xferActive), 32'h0);
    chk(rdQ.size() == 0, "R7", "read words outstanding", 32'(rdQ.size()), 32'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule